// File: doc/BRIEF.md
# Sparse Weight Packet Multiply-Accumulate Engine

The engine takes a dense stream of signed weights, one position per accepted beat, and keeps only the nonzero ones. Each surviving weight is wrapped into a packet that pairs the weight's stream position with its value. Packets cross a one-entry internal channel into a compute element. The compute element keeps its activations in a local memory. For each packet it reads the activation addressed by the packet's position, multiplies the two values, and adds the product into a wide accumulator. Work happens only when a packet arrives. A zero weight costs one input beat and nothing more.

Before a vector is streamed, software preloads the activation memory through a write port. The vector is then streamed with a start flag on its first beat and a last flag on its final beat. The engine pulses a done strobe once the sum is complete. The accumulator and a packet counter can then be read, and cleared for the next vector once the pipeline has drained.

Top module: `sparse_weight_engine`

## Requirements
- R1: After reset, `wReady` is 1, `done` is 0, `accOut` is 0 and `pktCount` is 0.
- R2: A weight of value zero is accepted in the cycle it is presented. It produces no packet, does not change `accOut`, and does not increment `pktCount`.
- R3: Each accepted beat, zero or not, takes the next stream position. A beat with `wSov`=1 takes position 0. A nonzero weight at position p adds act[p] * weight to `accOut`, with both operands 16-bit two's complement and the sum 40-bit two's complement.
- R4: `wReady` is 0 only while a nonzero weight is presented, the packet channel is occupied, and the channel cannot drain. The channel cannot drain in any cycle in which `actWe` is 1.
- R5: With `actWe`=1, `actWdata` is written to activation address `actAddr` at the clock edge. The write takes priority over a packet's operand read.
- R6: `done` is a single-cycle pulse. It is raised in the first cycle in which `accOut` holds the full sum of a vector whose last beat is nonzero. When the last beat is zero, `done` is raised after every earlier packet has been accumulated.
- R7: `accClear`=1 sets `accOut` and `pktCount` to 0 at the clock edge, but only when no packet is in the operand or product stage. Otherwise the clear request is dropped.
- R8: `pktCount` increments by one for each accumulated packet, so after a vector it equals the number of nonzero weights in that vector.
- R9: A vector of 256 weights of -32768 against 256 activations of -32768 yields exactly 2^38 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wValid | input | 1 | Weight beat valid |
| wReady | output | 1 | Weight beat accepted when high with wValid |
| wData | input | 16 | Signed weight value |
| wSov | input | 1 | Beat is the first of a vector (position 0) |
| wLast | input | 1 | Beat is the last of a vector |
| actWe | input | 1 | Activation memory write enable |
| actAddr | input | 8 | Activation memory write address |
| actWdata | input | 16 | Signed activation value |
| accClear | input | 1 | Clear accumulator and packet counter when drained |
| accOut | output | 40 | Signed accumulator |
| done | output | 1 | Pulse when a vector's sum is complete |
| pktCount | output | 16 | Packets accumulated since last clear |

## Verification
Most faults in this block show up as a wrong sum at the next `done`. A lost or duplicated packet, an index counter that is off by one, or an index that fails to restart on `wSov` each give a wrong value, and a lost or duplicated packet also shows up within a few cycles as a wrong `pktCount`. A zero weight that leaks into the channel shows up as an extra count. A broken stall path shows up at once as `wReady` dropping for a zero weight, or as a skipped packet while writes hold the channel. A clear honoured while data is in flight shows up at the following `done` as a partial sum.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic take;     // a weight beat is accepted
    logic pktLoad;  // the accepted beat is nonzero and enters the channel
    logic fire;     // channel packet moves to the operand stage
    logic s2Load;   // operand stage moves to the product stage
    logic accAdd;   // product is added to the accumulator
    logic accClr;   // accumulator and counter are zeroed
    logic memWr;    // activation memory write
  } ctrl_strobe_t;
endpackage

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
  import sdw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wValid,
  input  logic         wLast,
  input  logic         wIsZero,
  input  logic         actWe,
  input  logic         accClear,
  output logic         wReady,
  output logic         done,
  output ctrl_strobe_t st
);
  logic pktValid, pktLast;
  logic s1Valid, s1Last;
  logic s2Valid, s2Last;
  logic zeroLastPend, doneQ;
  logic chanReady, fire, take, idle, zeroDone;

  assign chanReady = !actWe;
  assign fire      = pktValid && chanReady;
  assign wReady    = !pktValid || fire || wIsZero;
  assign take      = wValid && wReady;
  assign idle      = !pktValid && !s1Valid && !s2Valid;
  assign zeroDone  = zeroLastPend && idle;

  always_comb begin
    st         = '0;
    st.take    = take;
    st.pktLoad = take && !wIsZero;
    st.fire    = fire;
    st.s2Load  = s1Valid;
    st.accAdd  = s2Valid;
    st.accClr  = accClear && !s1Valid && !s2Valid;
    st.memWr   = actWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktValid     <= 1'b0;
      pktLast      <= 1'b0;
      s1Valid      <= 1'b0;
      s1Last       <= 1'b0;
      s2Valid      <= 1'b0;
      s2Last       <= 1'b0;
      zeroLastPend <= 1'b0;
      doneQ        <= 1'b0;
    end else begin
      pktValid <= st.pktLoad || (pktValid && !fire);
      if (st.pktLoad) pktLast <= wLast;
      s1Valid <= fire;
      s1Last  <= fire && pktLast;
      s2Valid <= s1Valid;
      s2Last  <= s1Valid && s1Last;
      doneQ   <= (s2Valid && s2Last) || zeroDone;
      if (take && wLast && wIsZero) zeroLastPend <= 1'b1;
      else if (zeroDone)            zeroLastPend <= 1'b0;
    end
  end

  assign done = doneQ;

  // R2: a zero beat never fills an empty or draining channel
  p_zero_no_packet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (take && wIsZero && (!pktValid || fire)) |=> !pktValid);
  // R4: a stall has exactly one cause
  p_stall_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    !wReady |-> (pktValid && actWe && !wIsZero));
  // R4: a stalled packet stays in the channel
  p_pkt_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !fire) |=> pktValid);
  // R7: a clear is only honoured with an empty pipeline
  p_clear_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.accClr |-> (!s1Valid && !s2Valid));
  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/sdw_dpath.sv
module sdw_dpath
  import sdw_pkg::*;
#(
  parameter int W_W   = 16,
  parameter int IDX_W = 8,
  parameter int ACC_W = 40,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_strobe_t            st,
  input  logic signed [W_W-1:0]   wData,
  input  logic                    wSov,
  input  logic [IDX_W-1:0]        actAddr,
  input  logic signed [W_W-1:0]   actWdata,
  output logic                    wIsZero,
  output logic signed [ACC_W-1:0] accOut,
  output logic [CNT_W-1:0]        pktCount
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int PROD_W = 2 * W_W;

  logic signed [W_W-1:0]    actMem [DEPTH];
  logic [IDX_W-1:0]         idxCnt, curIdx, pktIdx;
  logic signed [W_W-1:0]    pktVal, s1Act, s1Val;
  logic signed [PROD_W-1:0] s2Prod;
  logic signed [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]         cnt;

  assign wIsZero = (wData == '0);
  assign curIdx  = wSov ? '0 : idxCnt;

  always_ff @(posedge clk) begin
    if (st.memWr) actMem[actAddr] <= actWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxCnt <= '0;
      pktIdx <= '0;
      pktVal <= '0;
      s1Act  <= '0;
      s1Val  <= '0;
      s2Prod <= '0;
      acc    <= '0;
      cnt    <= '0;
    end else begin
      if (st.take) idxCnt <= curIdx + 1'b1;
      if (st.pktLoad) begin
        pktIdx <= curIdx;
        pktVal <= wData;
      end
      if (st.fire) begin
        s1Act <= actMem[pktIdx];
        s1Val <= pktVal;
      end
      if (st.s2Load) s2Prod <= s1Act * s1Val;
      if (st.accClr) begin
        acc <= '0;
        cnt <= '0;
      end else if (st.accAdd) begin
        acc <= acc + ACC_W'(s2Prod);
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign accOut   = acc;
  assign pktCount = cnt;

  // R7: the accumulator moves only on an add or a clear
  p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!st.accAdd && !st.accClr) |=> $stable(accOut));
  // R8: each accumulated packet counts once
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st.accAdd && !st.accClr) |=> (pktCount == $past(pktCount) + 1'b1));
  // R3: a start-of-vector beat restarts positions
  p_idx_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st.take && wSov) |=> (idxCnt == IDX_W'(1)));
  // R3: a packet keeps its position while waiting in the channel
  p_pkt_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!st.pktLoad) |=> $stable(pktIdx));
endmodule

// File: rtl/sparse_weight_engine.sv
module sparse_weight_engine
  import sdw_pkg::*;
#(
  parameter int W_W   = 16,
  parameter int IDX_W = 8,
  parameter int ACC_W = 40,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wValid,
  output logic                    wReady,
  input  logic signed [W_W-1:0]   wData,
  input  logic                    wSov,
  input  logic                    wLast,
  input  logic                    actWe,
  input  logic [IDX_W-1:0]        actAddr,
  input  logic signed [W_W-1:0]   actWdata,
  input  logic                    accClear,
  output logic signed [ACC_W-1:0] accOut,
  output logic                    done,
  output logic [CNT_W-1:0]        pktCount
);
  ctrl_strobe_t st;
  logic         wIsZero;

  sdw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wValid   (wValid),
    .wLast    (wLast),
    .wIsZero  (wIsZero),
    .actWe    (actWe),
    .accClear (accClear),
    .wReady   (wReady),
    .done     (done),
    .st       (st)
  );

  sdw_dpath #(
    .W_W   (W_W),
    .IDX_W (IDX_W),
    .ACC_W (ACC_W),
    .CNT_W (CNT_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .wData    (wData),
    .wSov     (wSov),
    .actAddr  (actAddr),
    .actWdata (actWdata),
    .wIsZero  (wIsZero),
    .accOut   (accOut),
    .pktCount (pktCount)
  );
endmodule

// File: tb/sparse_weight_engine_tb.sv
module sparse_weight_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               wValid = 1'b0, wSov = 1'b0, wLast = 1'b0;
  logic signed [15:0] wData = '0;
  logic               actWe = 1'b0;
  logic [7:0]         actAddr = '0;
  logic signed [15:0] actWdata = '0;
  logic               accClear = 1'b0;
  logic               wReady, done;
  logic signed [39:0] accOut;
  logic [15:0]        pktCount;

  int checks = 0, failures = 0;
  logic signed [15:0] actModel [256];
  logic signed [15:0] vecW [256];
  int vecLen;

  always #(CLK_PERIOD/2) clk = ~clk;

  sparse_weight_engine dut_i (
    .clk(clk), .rstN(rstN), .wValid(wValid), .wReady(wReady), .wData(wData),
    .wSov(wSov), .wLast(wLast), .actWe(actWe), .actAddr(actAddr),
    .actWdata(actWdata), .accClear(accClear), .accOut(accOut), .done(done),
    .pktCount(pktCount)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expSum();
    longint s = 0;
    for (int i = 0; i < vecLen; i++) s += longint'(actModel[i]) * longint'(vecW[i]);
    return s;
  endfunction

  function automatic int expCnt();
    int c = 0;
    for (int i = 0; i < vecLen; i++) if (vecW[i] != 0) c++;
    return c;
  endfunction

  task automatic preload(input int a, input logic signed [15:0] v);
    @(negedge clk);
    actWe = 1'b1; actAddr = 8'(a); actWdata = v;
    actModel[a] = v;
    @(posedge clk);
    @(negedge clk);
    actWe = 1'b0;
  endtask

  task automatic doClear();
    @(negedge clk);
    accClear = 1'b1;
    @(negedge clk);
    accClear = 1'b0;
  endtask

  // Stream vecW[0..vecLen-1] with random idle beats
  task automatic sendVec(input bit gaps);
    int i = 0;
    while (i < vecLen) begin
      @(negedge clk);
      if (gaps && ($urandom % 4 == 0)) begin
        wValid = 1'b0;
        @(posedge clk);
      end else begin
        wValid = 1'b1; wData = vecW[i];
        wSov = (i == 0); wLast = (i == vecLen - 1);
        #1;
        if (wReady) begin
          @(posedge clk);
          i++;
        end else @(posedge clk);
      end
    end
    @(negedge clk);
    wValid = 1'b0; wSov = 1'b0; wLast = 1'b0; wData = '0;
  endtask

  task automatic waitDone(input string req, input longint es, input int ec);
    int n = 0;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
    check({req, " done seen"}, done, 1);
    check({req, " sum"}, accOut, longint'(40'(es)) - ((es < 0) ? 0 : 0));
    check({req, " count R8"}, pktCount, ec);
    @(negedge clk);
    check("R6 done single pulse", done, 0);
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 wReady", wReady, 1);
    check("R1 done", done, 0);
    check("R1 accOut", accOut, 0);
    check("R1 pktCount", pktCount, 0);

    // R5: preload every activation with random values
    for (int a = 0; a < 256; a++) preload(a, 16'($urandom));

    // R2: all-zero vector, last beat zero (R6)
    doClear();
    vecLen = 12;
    for (int i = 0; i < vecLen; i++) vecW[i] = '0;
    sendVec(1'b0);
    waitDone("R2 all zero", 0, 0);

    // R3: random sparse vectors, index restarts each vector
    for (int v = 0; v < 10; v++) begin
      doClear();
      check("R7 clear when idle", accOut, 0);
      vecLen = 1 + ($urandom % 60);
      for (int i = 0; i < vecLen; i++)
        vecW[i] = ($urandom % 2 == 0) ? 16'sd0 : 16'($urandom);
      if (v == 3) vecW[vecLen-1] = 16'sd0;   // R6 zero last beat
      if (v == 4) vecW[vecLen-1] = 16'sd7;
      sendVec(1'b1);
      waitDone("R3 random vector", expSum(), expCnt());
    end

    // R4/R5: preload write blocks the channel
    doClear();
    @(negedge clk);
    actWe = 1'b1; actAddr = 8'd200; actWdata = actModel[200];
    wValid = 1'b1; wSov = 1'b1; wLast = 1'b0; wData = 16'sd3;
    #1 check("R4 first nonzero accepted", wReady, 1);
    @(posedge clk);
    @(negedge clk);
    wSov = 1'b0; wData = -16'sd5;
    #1 check("R4 blocked nonzero", wReady, 0);
    @(posedge clk);
    @(negedge clk);
    #1 check("R4 still blocked", wReady, 0);
    wData = 16'sd0;
    #1 check("R4 zero accepted while blocked", wReady, 1);
    @(posedge clk);
    @(negedge clk);
    wData = 16'sd11; wLast = 1'b1;
    #1 check("R4 blocked again", wReady, 0);
    @(posedge clk);
    @(negedge clk);
    actWe = 1'b0;
    #1 check("R4 released", wReady, 1);
    @(posedge clk);
    @(negedge clk);
    wValid = 1'b0; wLast = 1'b0; wData = '0;
    vecLen = 3; vecW[0] = 16'sd3; vecW[1] = 16'sd0; vecW[2] = 16'sd11;
    waitDone("R4 R3 stalled vector", expSum(), 2);

    // R7: clear during flight is dropped
    doClear();
    vecLen = 4;
    vecW[0] = 16'sd100; vecW[1] = 16'sd0; vecW[2] = -16'sd9; vecW[3] = 16'sd21;
    sendVec(1'b0);
    // last beat accepted one edge ago; its packet is in the operand stage next
    accClear = 1'b1;
    @(negedge clk);
    accClear = 1'b0;
    waitDone("R7 ignored clear", expSum(), 3);
    doClear();
    check("R7 clear after drain acc", accOut, 0);
    check("R7 clear after drain count", pktCount, 0);

    // R9: extreme operands across all 256 positions
    for (int a = 0; a < 256; a++) preload(a, -16'sd32768);
    doClear();
    vecLen = 256;
    for (int i = 0; i < vecLen; i++) vecW[i] = -16'sd32768;
    sendVec(1'b0);
    waitDone("R9 extreme", 64'sd1 << 38, 256);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule